// File: doc/BRIEF.md
# Core Power-Down Mode Controller

This block holds a processor's low-power state and drives the clock enables that come out of it. The instruction decoder sends a one-cycle strobe when it executes a halt or a sleep instruction. A halt stops only the core clock. A sleep is deeper and stops both the core clock and the peripheral clock. While either state is held, the block watches NMI, debug interrupts and every maskable interrupt request line. Any one of them restores the clocks, whatever the mask state. Reset also restores them, asynchronously.

When it wakes, the block also tells the instruction sequencer what to do next. In one case it asks for the interrupt handler to be entered after the instruction that follows the halt or sleep instruction. In the other case execution simply continues. The handler is taken only when the waking source is NMI or debug, or when a pending maskable request has both its own enable bit and the global enable set.

Top module: `pwrdn_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces state 2'b00 (RUN), drives core_clk_en and periph_clk_en high and drives take_irq_after_next low, even while the block is in a low-power state.
- R2: A halt_strobe in RUN moves the block to state 2'b01 (HALT) on the next clock edge. With no wake source present, core_clk_en is then low and periph_clk_en stays high.
- R3: A sleep_strobe in RUN moves the block to state 2'b10 (SLEEP) on the next clock edge. With no wake source present, both clock enables are then low.
- R4: In HALT or SLEEP, any set bit of irq_pending wakes the block whatever irq_enable and global_ie hold. Both clock enables go high in the same cycle, and the state is RUN after the next edge.
- R5: In HALT or SLEEP, nmi or debug_irq wakes the block in the same way as R4, and take_irq_after_next is high in that cycle.
- R6: take_irq_after_next is high for exactly one cycle when a wake is caused by a request bit i where irq_pending[i], irq_enable[i] and global_ie are all high.
- R7: A wake that comes only from requests failing the R6 condition (global_ie low, or no pending bit with its enable set) restores the clocks and leaves take_irq_after_next low.
- R8: A halt or sleep strobe that arrives while a wake source is already asserted gives exactly one cycle in the low-power state. The block wakes in that cycle, pulses take_irq_after_next per R5–R7, and returns to RUN.
- R9: In HALT or SLEEP, halt_strobe and sleep_strobe are ignored: the state and the clock enables are unchanged.
- R10: If halt_strobe and sleep_strobe are both high in RUN, the block enters HALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, also a wake source |
| halt_strobe | input | 1 | One-cycle request from the decoder to enter HALT |
| sleep_strobe | input | 1 | One-cycle request from the decoder to enter SLEEP |
| irq_pending | input | NUM_IRQ | Maskable interrupt request lines |
| irq_enable | input | NUM_IRQ | Per-source interrupt enable bits |
| global_ie | input | 1 | Global interrupt enable flag |
| nmi | input | 1 | Non-maskable interrupt request |
| debug_irq | input | 1 | Debug interrupt request |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| take_irq_after_next | output | 1 | Pulse: enter the handler after the next instruction |
| pd_state | output | 2 | Current state: 00 RUN, 01 HALT, 10 SLEEP |

## Verification
The state register is brought out on pd_state, so a wrong transition shows at the ports one edge after the strobe or wake that caused it. A wrong state also shows combinationally on the clock enables. A lost wake leaves a clock enable low in the same cycle the source is asserted. A stuck state shows up as a take_irq_after_next pulse that lasts longer than one cycle, or one that fires or fails to fire in the wake cycle against the mask inputs.

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_strobe,
  input  logic               sleep_strobe,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic               global_ie,
  input  logic               nmi,
  input  logic               debug_irq,
  output logic               core_clk_en,
  output logic               periph_clk_en,
  output logic               take_irq_after_next,
  output logic [1:0]         pd_state
);

  localparam logic [1:0] ST_RUN   = 2'b00;
  localparam logic [1:0] ST_HALT  = 2'b01;
  localparam logic [1:0] ST_SLEEP = 2'b10;

  logic [1:0] state_q;
  logic       low_pwr;
  logic       wake;
  logic       irq_taken;

  assign low_pwr   = (state_q != ST_RUN);
  assign wake      = (|irq_pending) | nmi | debug_irq;
  assign irq_taken = nmi | debug_irq | ((|(irq_pending & irq_enable)) & global_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else if (low_pwr) begin
      if (wake) state_q <= ST_RUN;
    end else if (halt_strobe) begin
      state_q <= ST_HALT;
    end else if (sleep_strobe) begin
      state_q <= ST_SLEEP;
    end
  end

  assign core_clk_en         = !low_pwr | wake;
  assign periph_clk_en       = (state_q != ST_SLEEP) | wake;
  assign take_irq_after_next = low_pwr & wake & irq_taken;
  assign pd_state            = state_q;

  assert_sleep_gates_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == ST_SLEEP && !wake) |-> (!core_clk_en && !periph_clk_en));

  assert_halt_keeps_periph_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == ST_HALT) |-> periph_clk_en);

  assert_wake_returns_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state != ST_RUN && (|irq_pending)) |=> (pd_state == ST_RUN));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_after_next |=> !take_irq_after_next);

  assert_nmi_takes_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state != ST_RUN && nmi) |-> (take_irq_after_next && core_clk_en));

  assert_cross_strobe_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state != ST_RUN && !wake) |=> $stable(pd_state));

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pd_state != 2'b11);

endmodule

// File: tb/test_pwrdn_ctrl.sv
module test_pwrdn_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       h;
    logic       s;
    logic [3:0] pend;
    logic [3:0] en;
    logic       gie;
    logic       nmi;
    logic       dbg;
    logic [1:0] st;
    logic       cen;
    logic       pen;
    logic       tk;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd1},  // R1 idle RUN
    '{1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd2},  // R2 halt strobe
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd1,1'b0,1'b1,1'b0,4'd2},  // R2 in HALT
    '{1'b0,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,2'd1,1'b0,1'b1,1'b0,4'd9},  // R9 sleep in HALT
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd1,1'b0,1'b1,1'b0,4'd9},  // R9 still HALT
    '{1'b0,1'b0,4'h1,4'h0,1'b1,1'b0,1'b0,2'd1,1'b1,1'b1,1'b0,4'd4},  // R4 R7 masked wake
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd4},  // R4 back to RUN
    '{1'b0,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd3},  // R3 sleep strobe
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd2,1'b0,1'b0,1'b0,4'd3},  // R3 in SLEEP
    '{1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd2,1'b0,1'b0,1'b0,4'd9},  // R9 halt in SLEEP
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd2,1'b0,1'b0,1'b0,4'd9},  // R9 still SLEEP
    '{1'b0,1'b0,4'h4,4'h4,1'b1,1'b0,1'b0,2'd2,1'b1,1'b1,1'b1,4'd6},  // R6 enabled wake
    '{1'b0,1'b0,4'h4,4'h4,1'b1,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd6},  // R6 single pulse
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd6},
    '{1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd5},  // R5 halt
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b1,1'b0,2'd1,1'b1,1'b1,1'b1,4'd5},  // R5 nmi wake
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd5},
    '{1'b0,1'b1,4'h0,4'h0,1'b0,1'b0,1'b1,2'd0,1'b1,1'b1,1'b0,4'd8},  // R8 sleep with dbg
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b1,2'd2,1'b1,1'b1,1'b1,4'd8},  // R8 one cycle SLEEP
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd8},  // R8 RUN again
    '{1'b1,1'b0,4'h2,4'h2,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd8},  // R8 halt with irq
    '{1'b0,1'b0,4'h2,4'h2,1'b0,1'b0,1'b0,2'd1,1'b1,1'b1,1'b0,4'd7},  // R7 gie low
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd8},
    '{1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd10}, // R10 both strobes
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd1,1'b0,1'b1,1'b0,4'd10}, // R10 HALT won
    '{1'b0,1'b0,4'h8,4'h1,1'b1,1'b0,1'b0,2'd1,1'b1,1'b1,1'b0,4'd7},  // R7 enable on other bit
    '{1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,4'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_strobe = 1'b0, sleep_strobe = 1'b0;
  logic [3:0] irq_pending = '0, irq_enable = '0;
  logic global_ie = 1'b0, nmi = 1'b0, debug_irq = 1'b0;
  logic core_clk_en, periph_clk_en, take_irq_after_next;
  logic [1:0] pd_state;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrdn_ctrl #(.NUM_IRQ(4)) i_pwrdn_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_strobe(halt_strobe), .sleep_strobe(sleep_strobe),
    .irq_pending(irq_pending), .irq_enable(irq_enable), .global_ie(global_ie),
    .nmi(nmi), .debug_irq(debug_irq), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .take_irq_after_next(take_irq_after_next),
    .pd_state(pd_state)
  );

  task automatic check(input int rq, input string what, input logic [1:0] st,
                       input logic cen, input logic pen, input logic tk);
    n_run++;
    if ({pd_state, core_clk_en, periph_clk_en, take_irq_after_next} !== {st, cen, pen, tk}) begin
      n_fail++;
      $display("FAIL R%0d %s: got st=%b cen=%b pen=%b tk=%b expected st=%b cen=%b pen=%b tk=%b",
               rq, what, pd_state, core_clk_en, periph_clk_en, take_irq_after_next,
               st, cen, pen, tk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check(1, "R1 in reset", 2'd0, 1'b1, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      halt_strobe = TBL[i].h; sleep_strobe = TBL[i].s;
      irq_pending = TBL[i].pend; irq_enable = TBL[i].en;
      global_ie = TBL[i].gie; nmi = TBL[i].nmi; debug_irq = TBL[i].dbg;
      #1;
      check(int'(TBL[i].rq), $sformatf("row %0d", i), TBL[i].st, TBL[i].cen, TBL[i].pen, TBL[i].tk);
    end
    // R1: asynchronous reset while in SLEEP
    @(negedge clk);
    {halt_strobe, sleep_strobe, irq_pending, irq_enable, global_ie, nmi, debug_irq} = '0;
    sleep_strobe = 1'b1;
    @(negedge clk); sleep_strobe = 1'b0; #1;
    check(3, "R3 before reset", 2'd2, 1'b0, 1'b0, 1'b0);
    #2; rst_n = 1'b0; #1;
    check(1, "R1 reset exits SLEEP", 2'd0, 1'b1, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    // R6 with global enable and matching enable among several pending bits
    halt_strobe = 1'b1;
    @(negedge clk); halt_strobe = 1'b0; irq_pending = 4'hA; irq_enable = 4'h8; global_ie = 1'b1; #1;
    check(6, "R6 multi pending", 2'd1, 1'b1, 1'b1, 1'b1);
    @(negedge clk); irq_pending = '0; irq_enable = '0; global_ie = 1'b0; #1;
    check(6, "R6 after wake", 2'd0, 1'b1, 1'b1, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule